// File: doc/BRIEF.md
# Processing-Element Command Dispatcher

This block sits between the control processor of a processing element and the engines that do the work. Each message arrives on one valid/ready input port. It carries a flag that says whether it is an internal command, a 3-bit opcode, a completion tag and a payload. Internal commands wait a fixed number of overhead cycles and then go to one of four destinations, chosen by opcode class: the DMA engine, the GEMM engine, the MATH engine, or the tiled-pipeline sequencer. An opcode outside the routing table dispatches nothing. Its tag comes back at once on the completion bus. Messages that are not commands skip the overhead and leave unchanged on a bypass port.

One staging slot holds the message that is counting down. Each destination has its own output register. A destination that is stalled therefore holds only its own traffic, and several commands can be outstanding across the engines at the same time. The overhead is taken from the configuration input when a command is accepted.

Top module: `pe_cmd_dispatch`

## Requirements
- R1: After reset every output valid and `doneValid` are low and `inReady` is high.
- R2: Commands with opcode 0 (DMA read) or opcode 1 (DMA write) appear only on the DMA port, as the word {opcode, tag, payload}.
- R3: Opcode 2 appears only on the GEMM port, and opcode 3 appears only on the MATH port.
- R4: Opcode 4 (composite) appears only on the sequencer port and never on an engine port.
- R5: Opcodes 5 to 7 reach no output port. Their tag is reported on `doneValid`/`doneTag` for exactly one cycle.
- R6: Take a command accepted at a clock edge while all destinations are ready. Its output valid first rises after the edge that comes `cfgOverhead`+1 edges later. An overhead of zero gives a valid one edge after acceptance.
- R7: A message with `inIsCmd` low appears bit-exact on the forward port one edge after acceptance, whatever the value of `cfgOverhead`.
- R8: A valid output whose ready is low keeps its valid high and its word stable.
- R9: While one port holds a word that has not been accepted, a later command for a different port is still accepted and delivered.
- R10: Words leave each port in the order the messages were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgOverhead | input | OVH_W | Overhead cycles applied to each command |
| inValid | input | 1 | Input message valid |
| inReady | output | 1 | Input message accepted when high with inValid |
| inIsCmd | input | 1 | 1 = internal command, 0 = bypass message |
| inOp | input | 3 | Opcode |
| inTag | input | TAG_W | Completion tag |
| inPayload | input | PAY_W | Command payload |
| dmaValid | output | 1 | DMA port valid |
| dmaReady | input | 1 | DMA port ready |
| dmaWord | output | 3+TAG_W+PAY_W | DMA port {op, tag, payload} |
| gemmValid | output | 1 | GEMM port valid |
| gemmReady | input | 1 | GEMM port ready |
| gemmWord | output | 3+TAG_W+PAY_W | GEMM port word |
| mathValid | output | 1 | MATH port valid |
| mathReady | input | 1 | MATH port ready |
| mathWord | output | 3+TAG_W+PAY_W | MATH port word |
| seqValid | output | 1 | Sequencer port valid |
| seqReady | input | 1 | Sequencer port ready |
| seqWord | output | 3+TAG_W+PAY_W | Sequencer port word |
| fwdValid | output | 1 | Bypass port valid |
| fwdReady | input | 1 | Bypass port ready |
| fwdWord | output | 3+TAG_W+PAY_W | Bypass port word |
| doneValid | output | 1 | Completion pulse for an unknown opcode |
| doneTag | output | TAG_W | Tag of that completion |

## Verification
The bench stalls the DMA port and sends a GEMM command behind a DMA command. A design whose staging or outputs were shared would leave the GEMM word stuck behind the stalled DMA word. The bench measures latency at overheads of zero and three, and for bypass traffic under a large overhead. This catches off-by-one countdowns and bypass messages that wrongly wait. A random phase with random port readiness covers several more faults: unknown opcodes that leak onto a port or lose their completion, the two DMA opcodes splitting across ports, and words that change or get reordered while a port is held.

// File: rtl/pe_disp_pkg.sv
package pe_disp_pkg;
  localparam int OP_W  = 3;
  localparam int NPORT = 5;

  localparam logic [OP_W-1:0] OPC_DMA_RD = 3'd0;
  localparam logic [OP_W-1:0] OPC_DMA_WR = 3'd1;
  localparam logic [OP_W-1:0] OPC_GEMM   = 3'd2;
  localparam logic [OP_W-1:0] OPC_MATH   = 3'd3;
  localparam logic [OP_W-1:0] OPC_COMP   = 3'd4;

  // destination index equals output port bit position
  typedef enum logic [2:0] {
    DST_DMA  = 3'd0,
    DST_GEMM = 3'd1,
    DST_MATH = 3'd2,
    DST_SEQ  = 3'd3,
    DST_FWD  = 3'd4,
    DST_NONE = 3'd5
  } dest_e;

  typedef struct packed {
    logic             take;
    logic [NPORT-1:0] load;
    logic             ackUnknown;
  } strobe_t;
endpackage

// File: rtl/pe_disp_ctrl.sv
module pe_disp_ctrl
  import pe_disp_pkg::*;
#(
  parameter int OVH_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inIsCmd,
  input  logic [OP_W-1:0]      inOp,
  input  logic [OVH_W-1:0]     cfgOverhead,
  input  logic [NPORT-1:0]     portValid,
  input  logic [NPORT-1:0]     portReady,
  output logic                 inReady,
  output strobe_t              strb
);
  logic             slotFull;
  dest_e            slotDest;
  logic [OVH_W-1:0] timer;
  logic [NPORT-1:0] portFree;
  logic [NPORT-1:0] destHot;
  logic             slotExpired;
  logic             move;

  function automatic dest_e decodeDest(input logic isCmd, input logic [OP_W-1:0] op);
    if (!isCmd) return DST_FWD;
    case (op)
      OPC_DMA_RD, OPC_DMA_WR: return DST_DMA;
      OPC_GEMM:               return DST_GEMM;
      OPC_MATH:               return DST_MATH;
      OPC_COMP:               return DST_SEQ;
      default:                return DST_NONE;
    endcase
  endfunction

  always_comb begin
    portFree    = ~portValid | portReady;
    destHot     = (slotDest == DST_NONE) ? '0
                : ({{(NPORT-1){1'b0}}, 1'b1} << slotDest);
    slotExpired = slotFull && (timer == '0);
    move        = slotExpired && ((slotDest == DST_NONE) || (|(destHot & portFree)));
    inReady     = !slotFull || move;
    strb.take       = inValid && inReady;
    strb.load       = move ? destHot : '0;
    strb.ackUnknown = move && (slotDest == DST_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotFull <= 1'b0;
      slotDest <= DST_NONE;
      timer    <= '0;
    end else if (strb.take) begin
      slotFull <= 1'b1;
      slotDest <= decodeDest(inIsCmd, inOp);
      timer    <= inIsCmd ? cfgOverhead : '0;
    end else if (move) begin
      slotFull <= 1'b0;
    end else if (slotFull && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  // R6: a command with nonzero overhead never leaves on the next edge
  p_no_early_move_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && inIsCmd && cfgOverhead != '0) |=> (strb.load == '0 && !strb.ackUnknown));

  // R9: an accepted message always occupies the staging slot afterwards
  p_accept_fills_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> slotFull);
endmodule

// File: rtl/pe_disp_dp.sv
module pe_disp_dp
  import pe_disp_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int PAY_W = 16,
  localparam int WORD_W = OP_W + TAG_W + PAY_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [OP_W-1:0]              inOp,
  input  logic [TAG_W-1:0]             inTag,
  input  logic [PAY_W-1:0]             inPayload,
  input  logic [NPORT-1:0]             portReady,
  output logic [NPORT-1:0]             portValid,
  output logic [NPORT-1:0][WORD_W-1:0] portWord,
  output logic                         doneValid,
  output logic [TAG_W-1:0]             doneTag
);
  logic [WORD_W-1:0] slotWord;

  always_ff @(posedge clk) begin
    if (!rstN) slotWord <= '0;
    else if (strb.take) slotWord <= {inOp, inTag, inPayload};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneTag   <= '0;
    end else begin
      doneValid <= strb.ackUnknown;
      if (strb.ackUnknown) doneTag <= slotWord[PAY_W +: TAG_W];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        portValid[p] <= 1'b0;
        portWord[p]  <= '0;
      end else if (strb.load[p]) begin
        portValid[p] <= 1'b1;
        portWord[p]  <= slotWord;
      end else if (portReady[p]) begin
        portValid[p] <= 1'b0;
      end
    end

    // R8: a held word stays valid and unchanged
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
      (portValid[p] && !portReady[p]) |=> (portValid[p] && $stable(portWord[p])));

    // R8: control never loads a port that is still holding a word
    p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
      strb.load[p] |-> (!portValid[p] || portReady[p]));
  end

  // R2: each message goes to at most one destination
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.ackUnknown}));
endmodule

// File: rtl/pe_cmd_dispatch.sv
module pe_cmd_dispatch
  import pe_disp_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int PAY_W = 16,
  parameter int OVH_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [OVH_W-1:0]              cfgOverhead,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic                          inIsCmd,
  input  logic [2:0]                    inOp,
  input  logic [TAG_W-1:0]              inTag,
  input  logic [PAY_W-1:0]              inPayload,
  output logic                          dmaValid,
  input  logic                          dmaReady,
  output logic [2+TAG_W+PAY_W:0]        dmaWord,
  output logic                          gemmValid,
  input  logic                          gemmReady,
  output logic [2+TAG_W+PAY_W:0]        gemmWord,
  output logic                          mathValid,
  input  logic                          mathReady,
  output logic [2+TAG_W+PAY_W:0]        mathWord,
  output logic                          seqValid,
  input  logic                          seqReady,
  output logic [2+TAG_W+PAY_W:0]        seqWord,
  output logic                          fwdValid,
  input  logic                          fwdReady,
  output logic [2+TAG_W+PAY_W:0]        fwdWord,
  output logic                          doneValid,
  output logic [TAG_W-1:0]              doneTag
);
  localparam int WORD_W = OP_W + TAG_W + PAY_W;

  strobe_t                      strb;
  logic [NPORT-1:0]             portValid;
  logic [NPORT-1:0]             portReady;
  logic [NPORT-1:0][WORD_W-1:0] portWord;

  assign portReady = {fwdReady, seqReady, mathReady, gemmReady, dmaReady};

  pe_disp_ctrl #(.OVH_W(OVH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsCmd(inIsCmd), .inOp(inOp),
    .cfgOverhead(cfgOverhead), .portValid(portValid), .portReady(portReady),
    .inReady(inReady), .strb(strb)
  );

  pe_disp_dp #(.TAG_W(TAG_W), .PAY_W(PAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inOp(inOp), .inTag(inTag),
    .inPayload(inPayload), .portReady(portReady), .portValid(portValid),
    .portWord(portWord), .doneValid(doneValid), .doneTag(doneTag)
  );

  assign dmaValid  = portValid[DST_DMA];
  assign gemmValid = portValid[DST_GEMM];
  assign mathValid = portValid[DST_MATH];
  assign seqValid  = portValid[DST_SEQ];
  assign fwdValid  = portValid[DST_FWD];
  assign dmaWord   = portWord[DST_DMA];
  assign gemmWord  = portWord[DST_GEMM];
  assign mathWord  = portWord[DST_MATH];
  assign seqWord   = portWord[DST_SEQ];
  assign fwdWord   = portWord[DST_FWD];
endmodule

// File: tb/pe_cmd_dispatch_bench.sv
`timescale 1ns/1ps
module pe_cmd_dispatch_bench;
  localparam int TAG_W = 4;
  localparam int PAY_W = 16;
  localparam int OVH_W = 4;
  localparam int W = 3 + TAG_W + PAY_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [OVH_W-1:0] cfgOverhead = '0;
  logic inValid = 1'b0, inIsCmd = 1'b0;
  logic [2:0] inOp = '0;
  logic [TAG_W-1:0] inTag = '0;
  logic [PAY_W-1:0] inPayload = '0;
  logic inReady;
  logic [4:0] rdy = 5'b11111;
  logic [4:0] vld;
  logic [W-1:0] wDma, wGemm, wMath, wSeq, wFwd;
  logic doneValid;
  logic [TAG_W-1:0] doneTag;

  int vectors = 0, fails = 0;
  bit randomReady = 0;
  logic [4:0] stallMask = '0;
  bit finished = 0;

  logic [W-1:0] qDma[$], qGemm[$], qMath[$], qSeq[$], qFwd[$];
  logic [TAG_W-1:0] qDone[$];
  logic [W-1:0] heldWord[5];
  bit heldFlag[5];

  always #10 clk = ~clk;

  pe_cmd_dispatch #(.TAG_W(TAG_W), .PAY_W(PAY_W), .OVH_W(OVH_W)) u_pe_cmd_dispatch (
    .clk(clk), .rstN(rstN), .cfgOverhead(cfgOverhead), .inValid(inValid), .inReady(inReady),
    .inIsCmd(inIsCmd), .inOp(inOp), .inTag(inTag), .inPayload(inPayload),
    .dmaValid(vld[0]), .dmaReady(rdy[0]), .dmaWord(wDma),
    .gemmValid(vld[1]), .gemmReady(rdy[1]), .gemmWord(wGemm),
    .mathValid(vld[2]), .mathReady(rdy[2]), .mathWord(wMath),
    .seqValid(vld[3]), .seqReady(rdy[3]), .seqWord(wSeq),
    .fwdValid(vld[4]), .fwdReady(rdy[4]), .fwdWord(wFwd),
    .doneValid(doneValid), .doneTag(doneTag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] wordOf(input int p);
    case (p)
      0: return wDma; 1: return wGemm; 2: return wMath; 3: return wSeq; default: return wFwd;
    endcase
  endfunction

  function automatic int qSize(input int p);
    case (p)
      0: return qDma.size(); 1: return qGemm.size(); 2: return qMath.size();
      3: return qSeq.size(); default: return qFwd.size();
    endcase
  endfunction

  task automatic qPush(input int p, input logic [W-1:0] w);
    case (p)
      0: qDma.push_back(w); 1: qGemm.push_back(w); 2: qMath.push_back(w);
      3: qSeq.push_back(w); default: qFwd.push_back(w);
    endcase
  endtask

  task automatic qPop(input int p, output logic [W-1:0] w);
    case (p)
      0: w = qDma.pop_front(); 1: w = qGemm.pop_front(); 2: w = qMath.pop_front();
      3: w = qSeq.pop_front(); default: w = qFwd.pop_front();
    endcase
  endtask

  // expected destination from R2/R3/R4/R5/R7; 5 = none
  function automatic int expDest(input bit isCmd, input logic [2:0] op);
    if (!isCmd) return 4;
    case (op)
      3'd0, 3'd1: return 0;
      3'd2: return 1;
      3'd3: return 2;
      3'd4: return 3;
      default: return 5;
    endcase
  endfunction

  task automatic send(input bit isCmd, input logic [2:0] op, input logic [TAG_W-1:0] tag,
                      input logic [PAY_W-1:0] pay);
    int d;
    d = expDest(isCmd, op);
    if (d == 5) qDone.push_back(tag);
    else qPush(d, {op, tag, pay});
    @(negedge clk);
    inValid = 1'b1; inIsCmd = isCmd; inOp = op; inTag = tag; inPayload = pay;
    #3;
    while (!inReady) begin
      @(negedge clk);
      #3;
    end
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    logic [W-1:0] exp;
    forever begin
      @(negedge clk);
      for (int p = 0; p < 5; p++)
        rdy[p] = stallMask[p] ? 1'b0 : (randomReady ? (($urandom % 4) != 0) : 1'b1);
      #1;
      if (rstN) begin
        for (int p = 0; p < 5; p++) begin
          if (heldFlag[p] && vld[p])
            check(wordOf(p) == heldWord[p], "R8 held word stable", wordOf(p), heldWord[p]);
          else if (heldFlag[p])
            check(1'b0, "R8 held valid dropped", 0, 1);
          heldFlag[p] = vld[p] && !rdy[p];
          heldWord[p] = wordOf(p);
          if (vld[p] && rdy[p]) begin
            if (qSize(p) == 0) check(1'b0, "R2/R3/R4/R5 unexpected word on port", wordOf(p), p);
            else begin
              qPop(p, exp);
              check(wordOf(p) == exp, "R10 port word order/content", wordOf(p), exp);
            end
          end
        end
        if (doneValid) begin
          if (qDone.size() == 0) check(1'b0, "R5 unexpected done", doneTag, 0);
          else begin
            logic [TAG_W-1:0] t;
            t = qDone.pop_front();
            check(doneTag == t, "R5 done tag", doneTag, t);
          end
        end
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      if (qDma.size() + qGemm.size() + qMath.size() + qSeq.size() + qFwd.size() + qDone.size() == 0)
        break;
      @(posedge clk);
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic latency(input bit isCmd, input logic [2:0] op, input int p,
                         input int expN, input string req);
    int n;
    send(isCmd, op, 4'h9, 16'h1234);
    n = 0;
    do begin
      @(negedge clk);
      #2;
      n++;
    end while (!vld[p] && n < 40);
    check(n == expN, req, n, expN);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    check(vld == 5'b0, "R1 valids after reset", vld, 0);
    check(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    check(doneValid == 1'b0, "R1 done after reset", doneValid, 0);

    // R2 R3 R4 R5 directed routing
    send(1, 3'd0, 4'h1, 16'hA001);
    send(1, 3'd1, 4'h2, 16'hA002);
    send(1, 3'd2, 4'h3, 16'hA003);
    send(1, 3'd3, 4'h4, 16'hA004);
    send(1, 3'd4, 4'h5, 16'hA005);
    send(1, 3'd5, 4'h6, 16'hA006);
    send(1, 3'd7, 4'h7, 16'hA007);
    send(0, 3'd2, 4'h8, 16'hA008);
    drain();

    // R6 overhead latency, R7 bypass latency
    cfgOverhead = 4'd0;
    latency(1, 3'd2, 1, 2, "R6 latency overhead 0");
    drain();
    cfgOverhead = 4'd3;
    latency(1, 3'd3, 2, 5, "R6 latency overhead 3");
    drain();
    cfgOverhead = 4'd9;
    latency(0, 3'd1, 4, 2, "R7 bypass ignores overhead");
    drain();
    cfgOverhead = 4'd1;

    // R9 stalled DMA does not block a GEMM command behind it
    stallMask = 5'b00001;
    send(1, 3'd0, 4'hA, 16'hB00A);
    send(1, 3'd2, 4'hB, 16'hB00B);
    repeat (8) @(posedge clk);
    @(negedge clk);
    #2;
    check(qGemm.size() == 0, "R9 gemm delivered past stalled dma", qGemm.size(), 0);
    check(vld[0] == 1'b1 && qDma.size() == 1, "R9 dma still held", vld[0], 1);
    stallMask = 5'b0;
    drain();

    // random phase (R2 R3 R4 R5 R7 R8 R10)
    randomReady = 1;
    for (int i = 0; i < 120; i++) begin
      cfgOverhead = OVH_W'($urandom % 4);
      send(($urandom % 4) != 0, 3'($urandom), TAG_W'($urandom), PAY_W'($urandom));
    end
    randomReady = 0;
    drain();

    for (int p = 0; p < 5; p++)
      check(qSize(p) == 0, "R10 all expected words delivered", qSize(p), 0);
    check(qDone.size() == 0, "R5 all unknown completions seen", qDone.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule